// File: doc/BRIEF.md
# Prescaled 64-bit Compare Timer

This block is a free-running 64-bit up-counter with a 4-bit clock prescaler and a 64-bit comparator. When the comparator is enabled and the count reaches or passes the compare value, a sticky event flag is set. The flag can drive an interrupt line. In auto-increment mode each compare event adds a programmable step to the comparator, so one-shot compares become a periodic tick.

Software reaches the timer through a plain 32-bit register port. It has a write strobe, a read strobe, a word index, write data and read data. Read data is registered and appears in the cycle after the read strobe. The 64-bit quantities are accessed as two 32-bit halves. The count may only be loaded while counting is stopped. The divide ratio may be changed while counting without losing the count.

Top module: `cmp_timer64`

## Requirements
- R1: After reset every register reads zero, the interrupt output is low and the counter is stopped.
- R2: Word indexes are count-low 0, count-high 1, control 2, status 3, compare-low 4, compare-high 5 and step 6. Read data for the strobed index appears on the next cycle. Index 7 reads zero.
- R3: Control bit 0 enables counting, bit 1 enables the comparator, bit 2 enables the interrupt, bit 3 selects auto-increment, and bits 11:8 hold the prescale field P. All other control bits read zero. While counting, the count rises by one every P+1 clocks. The divide phase starts from zero on the edge that writes control.
- R4: The count is 64 bits and carries from the low half into the high half. Each half can be written separately while counting is stopped.
- R5: Writes to either count half while counting is enabled leave the count unchanged.
- R6: Rewriting the prescale field while counting keeps the current count and the other control bits. Later increments use the new ratio.
- R7: While the comparator is enabled and count >= compare, status bit 0 is set. It stays set until software clears it.
- R8: Writing status with bit 0 at 1 clears the flag. Writing it with bit 0 at 0 has no effect. A compare event in the same cycle wins over the clear.
- R9: The interrupt output is high exactly when the status flag and the interrupt enable are both set.
- R10: With auto-increment on, each cycle with a compare event adds the 32-bit step value to the comparator. With auto-increment off, the comparator keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| irq | output | 1 | Compare interrupt |

## Verification
The bench builds the timer with its default 32-bit data width and 4-bit prescale field. The full prescale range, up to a ratio of 16, can therefore be reached in a few dozen cycles. Counts are preloaded close to the 32-bit boundary, so the carry into the high half shows up within three ticks. Small compare and step values let several auto-increment events happen in a short window. The exact count, comparator and flag values can then be predicted from the edge on which each write lands.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        IDX_CNT_LO = 3'd0,
        IDX_CNT_HI = 3'd1,
        IDX_CTRL   = 3'd2,
        IDX_STAT   = 3'd3,
        IDX_CMP_LO = 3'd4,
        IDX_CMP_HI = 3'd5,
        IDX_STEP   = 3'd6
    } reg_idx_e;

    localparam int unsigned CTL_RUN   = 0;
    localparam int unsigned CTL_CMPEN = 1;
    localparam int unsigned CTL_IRQEN = 2;
    localparam int unsigned CTL_AINC  = 3;
    localparam int unsigned CTL_PSC_LSB = 8;

endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
    parameter int unsigned PSC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    typedef struct packed {
        logic [PSC_W-1:0] div;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.div == psc);
        if (restart || !run || tick) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cmp_en,
    input  logic              ainc,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              wr_step,
    input  logic              clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cmp,
    output logic [DATA_W-1:0] step,
    output logic              flag,
    output logic              evt
);

    localparam int unsigned PAD_W = CNT_W - DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cmp;
        logic [DATA_W-1:0] step;
        logic              flag;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        evt  = cmp_en && (cnt >= st_q.cmp);

        if (wr_lo) begin
            st_d.cmp = {st_q.cmp[CNT_W-1:DATA_W], wdata};
        end else if (wr_hi) begin
            st_d.cmp = {wdata[PAD_W-1:0], st_q.cmp[DATA_W-1:0]};
        end else if (evt && ainc) begin
            st_d.cmp = st_q.cmp + {{PAD_W{1'b0}}, st_q.step};
        end

        if (wr_step) begin
            st_d.step = wdata;
        end

        if (evt) begin
            st_d.flag = 1'b1;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp  = st_q.cmp;
    assign step = st_q.step;
    assign flag = st_q.flag;

endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PSC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int unsigned CNT_W   = 2 * DATA_W;
    localparam int unsigned PSC_MSB = CTL_PSC_LSB + PSC_W - 1;

    typedef struct packed {
        logic              run;
        logic              cmp_en;
        logic              irq_en;
        logic              ainc;
        logic [PSC_W-1:0]  psc;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rdata;
    } st_t;

    st_t st_q, st_d;

    logic              tick;
    logic              evt;
    logic              flag;
    logic [CNT_W-1:0]  cmp_q;
    logic [DATA_W-1:0] step_q;
    logic              wr_ctrl;
    logic              wr_stat;
    logic              wr_cmp_lo;
    logic              wr_cmp_hi;
    logic              wr_step;

    logic              run;
    logic              cmp_en;
    logic              irq_en;
    logic              ainc;
    logic [PSC_W-1:0]  psc;
    logic [CNT_W-1:0]  cnt_q;

    assign run    = st_q.run;
    assign cmp_en = st_q.cmp_en;
    assign irq_en = st_q.irq_en;
    assign ainc   = st_q.ainc;
    assign psc    = st_q.psc;
    assign cnt_q  = st_q.cnt;

    assign wr_ctrl   = bus_wr && (bus_addr == IDX_CTRL);
    assign wr_stat   = bus_wr && (bus_addr == IDX_STAT) && bus_wdata[0];
    assign wr_cmp_lo = bus_wr && (bus_addr == IDX_CMP_LO);
    assign wr_cmp_hi = bus_wr && (bus_addr == IDX_CMP_HI);
    assign wr_step   = bus_wr && (bus_addr == IDX_STEP);

    tmr_presc #(
        .PSC_W (PSC_W)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.run),
        .restart (wr_ctrl),
        .psc     (st_q.psc),
        .tick    (tick)
    );

    tmr_compare #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (st_q.cnt),
        .cmp_en  (st_q.cmp_en),
        .ainc    (st_q.ainc),
        .wr_lo   (wr_cmp_lo),
        .wr_hi   (wr_cmp_hi),
        .wr_step (wr_step),
        .clr     (wr_stat),
        .wdata   (bus_wdata),
        .cmp     (cmp_q),
        .step    (step_q),
        .flag    (flag),
        .evt     (evt)
    );

    function automatic logic [DATA_W-1:0] ctrl_view(input st_t s);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CTL_RUN]   = s.run;
        v[CTL_CMPEN] = s.cmp_en;
        v[CTL_IRQEN] = s.irq_en;
        v[CTL_AINC]  = s.ainc;
        v[PSC_MSB:CTL_PSC_LSB] = s.psc;
        return v;
    endfunction

    always_comb begin
        st_d = st_q;

        // counter: loads only while stopped, otherwise advances on tick
        if (!st_q.run && bus_wr && (bus_addr == IDX_CNT_LO)) begin
            st_d.cnt = {st_q.cnt[CNT_W-1:DATA_W], bus_wdata};
        end else if (!st_q.run && bus_wr && (bus_addr == IDX_CNT_HI)) begin
            st_d.cnt = {bus_wdata, st_q.cnt[DATA_W-1:0]};
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (wr_ctrl) begin
            st_d.run    = bus_wdata[CTL_RUN];
            st_d.cmp_en = bus_wdata[CTL_CMPEN];
            st_d.irq_en = bus_wdata[CTL_IRQEN];
            st_d.ainc   = bus_wdata[CTL_AINC];
            st_d.psc    = bus_wdata[PSC_MSB:CTL_PSC_LSB];
        end

        if (bus_rd) begin
            unique case (bus_addr)
                IDX_CNT_LO: st_d.rdata = st_q.cnt[DATA_W-1:0];
                IDX_CNT_HI: st_d.rdata = st_q.cnt[CNT_W-1:DATA_W];
                IDX_CTRL:   st_d.rdata = ctrl_view(st_q);
                IDX_STAT:   st_d.rdata = {{(DATA_W-1){1'b0}}, flag};
                IDX_CMP_LO: st_d.rdata = cmp_q[DATA_W-1:0];
                IDX_CMP_HI: st_d.rdata = cmp_q[CNT_W-1:DATA_W];
                IDX_STEP:   st_d.rdata = step_q;
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = flag & st_q.irq_en;

endmodule

// File: rtl/cmp_timer64_chk.sv
module cmp_timer64_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PSC_W  = 4,
    parameter int unsigned CNT_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [2:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              run,
    input logic              cmp_en,
    input logic              ainc,
    input logic [PSC_W-1:0]  psc,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  cmp_q,
    input logic [DATA_W-1:0] step_q,
    input logic              flag,
    input logic              irq
);

    logic cnt_wr, ctl_wr, stat_clr, cmp_wr;
    assign cnt_wr   = bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd1);
    assign ctl_wr   = bus_wr && (bus_addr == 3'd2);
    assign stat_clr = bus_wr && (bus_addr == 3'd3) && bus_wdata[0];
    assign cmp_wr   = bus_wr && (bus_addr == 3'd4 || bus_addr == 3'd5);

    // R4
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt_q));

    // R5
    run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    // R3
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && psc == '0 && !ctl_wr) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !stat_clr) |=> flag);

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && cnt_q >= cmp_q) |=> flag);

    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !(cmp_en && cnt_q >= cmp_q)) |=> !flag);

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    // R10
    ainc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && ainc && cnt_q >= cmp_q && !cmp_wr)
        |=> (cmp_q == $past(cmp_q) + {{(CNT_W-DATA_W){1'b0}}, $past(step_q)}));

    // R10
    cmp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ainc && !cmp_wr) |=> $stable(cmp_q));

endmodule

bind cmp_timer64 cmp_timer64_chk #(
    .DATA_W (DATA_W),
    .PSC_W  (PSC_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run       (run),
    .cmp_en    (cmp_en),
    .ainc      (ainc),
    .psc       (psc),
    .cnt_q     (cnt_q),
    .cmp_q     (cmp_q),
    .step_q    (step_q),
    .flag      (flag),
    .irq       (irq)
);

// File: tb/tb_cmp_timer64.sv
module tb_cmp_timer64;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    localparam logic [3:0] VEC_PSC  [NVEC] = '{4'd0, 4'd1, 4'd3, 4'd15, 4'd2};
    localparam int         VEC_WAIT [NVEC] = '{6, 8, 10, 40, 5};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] rv;
    logic [31:0] rv2;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer64 dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic clear_cnt();
        wr(3'd2, 32'h0);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {63'd0, irq}, 64'd0);
        for (int i = 0; i < 7; i++) begin
            rd(i[2:0], rv);
            chk("R1 reg zero", {32'd0, rv}, 64'd0);
        end

        // R2/R3 control readback, unused bits read zero, index 7 reads zero
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, rv);
        chk("R3 ctrl readback", {32'd0, rv}, 64'h0F0F);
        wr(3'd2, 32'h0);
        rd(3'd7, rv);
        chk("R2 idx7", {32'd0, rv}, 64'd0);
        wr(3'd3, 32'h1);

        // R3 prescale table
        for (int v = 0; v < NVEC; v++) begin
            clear_cnt();
            wr(3'd2, 32'h1 | ({28'd0, VEC_PSC[v]} << 8));
            repeat (VEC_WAIT[v]) @(negedge clk);
            wr(3'd2, 32'h0);
            rd(3'd0, rv);
            chk("R3 prescale count", {32'd0, rv},
                64'((VEC_WAIT[v] + 1) / (int'(VEC_PSC[v]) + 1)));
        end

        // R6 prescale rewrite while running keeps count
        clear_cnt();
        wr(3'd2, 32'h1);
        repeat (3) @(negedge clk);
        wr(3'd2, 32'h101);
        rd(3'd2, rv);
        chk("R6 ctrl kept", {32'd0, rv}, 64'h101);
        repeat (4) @(negedge clk);
        wr(3'd2, 32'h0);
        rd(3'd0, rv);
        chk("R6 count kept", {32'd0, rv}, 64'd7);

        // R5 count writes ignored while running
        clear_cnt();
        wr(3'd2, 32'h1);
        wr(3'd0, 32'h1234);
        wr(3'd1, 32'h5);
        wr(3'd2, 32'h0);
        rd(3'd0, rv);
        rd(3'd1, rv2);
        chk("R5 write ignored", {rv2, rv}, 64'd3);

        // R4 halves writable while stopped, carry into high half
        wr(3'd0, 32'hFFFF_FFFE);
        wr(3'd1, 32'h0);
        rd(3'd0, rv);
        chk("R4 low load", {32'd0, rv}, 64'hFFFF_FFFE);
        wr(3'd2, 32'h1);
        repeat (2) @(negedge clk);
        wr(3'd2, 32'h0);
        rd(3'd0, rv);
        rd(3'd1, rv2);
        chk("R4 carry", {rv2, rv}, 64'h1_0000_0001);

        // R7/R9 one-shot compare at 5
        clear_cnt();
        wr(3'd4, 32'd5);
        wr(3'd5, 32'd0);
        wr(3'd2, 32'h7);
        repeat (5) @(negedge clk);
        chk("R9 irq before event", {63'd0, irq}, 64'd0);
        @(negedge clk);
        chk("R9 irq on event", {63'd0, irq}, 64'd1);
        wr(3'd2, 32'h0);
        rd(3'd3, rv);
        chk("R7 flag set", {32'd0, rv}, 64'd1);
        rd(3'd4, rv);
        chk("R10 cmp unchanged", {32'd0, rv}, 64'd5);

        // R8/R9 clear semantics and gating
        wr(3'd3, 32'h0);
        rd(3'd3, rv);
        chk("R8 zero write no effect", {32'd0, rv}, 64'd1);
        chk("R9 irq gated off", {63'd0, irq}, 64'd0);
        wr(3'd2, 32'h4);
        chk("R9 irq enabled", {63'd0, irq}, 64'd1);
        wr(3'd3, 32'h1);
        chk("R9 irq after clear", {63'd0, irq}, 64'd0);
        rd(3'd3, rv);
        chk("R8 flag cleared", {32'd0, rv}, 64'd0);
        wr(3'd2, 32'h0);

        // R8 event wins over clear: comparator on with count already past
        wr(3'd2, 32'h2);
        wr(3'd3, 32'h1);
        rd(3'd3, rv);
        chk("R8 set wins", {32'd0, rv}, 64'd1);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h1);

        // R10 auto-increment: compare 3, step 4
        clear_cnt();
        wr(3'd4, 32'd3);
        wr(3'd5, 32'd0);
        wr(3'd6, 32'd4);
        wr(3'd2, 32'hB);
        repeat (9) @(negedge clk);
        wr(3'd2, 32'h0);
        rd(3'd0, rv);
        chk("R10 count", {32'd0, rv}, 64'd10);
        rd(3'd4, rv);
        chk("R10 cmp stepped", {32'd0, rv}, 64'd11);
        rd(3'd6, rv);
        chk("R2 step readback", {32'd0, rv}, 64'd4);
        rd(3'd3, rv);
        chk("R10 flag", {32'd0, rv}, 64'd1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule